// File: doc/BRIEF.md
# 4-bit ALU with carry chaining

This block is the arithmetic and logic unit of a very small processor with a 4-bit datapath. It takes two operands, the carry bit held in the status register and an operation code. It returns a 4-bit result, a new carry, a zero flag and an unsigned less-than flag. It also returns two write enables: one says whether the result register is written, and the other says whether the carry bit is updated.

Add, subtract and the two single-bit shifts all consume the stored carry and produce a new one. A program can therefore add, subtract or shift values wider than one nibble by running the same operation once per nibble, lowest nibble first. Compare computes the difference of the operands without the carry, and only the flags are kept. The block is purely combinational and has no clock or reset; the surrounding control logic registers whatever it needs.

Top module: `alu4_core`

## Requirements
- R1: Opcode 0 (add) gives result = (A + B + Cin) mod 16 and carry-out = bit 4 of that sum.
- R2: Opcode 1 (subtract) gives result = (A − B − Cin) mod 16 and carry-out = 1 exactly when A < B + Cin (a borrow occurred).
- R3: Opcode 6 (shift left) gives result = {A[2:0], Cin} and carry-out = A[3].
- R4: Opcode 7 (shift right) gives result = {Cin, A[3:1]} and carry-out = A[0].
- R5: Opcodes 2 (AND), 3 (OR) and 5 (XOR) give the bitwise combination of A and B.
- R6: Opcode 4 (NOT) gives result = ~A; B has no effect on any output except the less flag.
- R7: Opcode 8 (compare) puts (A − B) mod 16 on the result bus with no carry-in, and signals that neither the result register nor the carry is written.
- R8: The carry write enable is 1 for opcodes 0, 1, 6 and 7 only. For every other opcode, carry-out equals Cin, so the stored carry is preserved.
- R9: For every opcode, the zero flag is 1 exactly when the 4-bit result is 0000. For compare, this means A == B.
- R10: For every opcode, the less flag is 1 exactly when A < B as unsigned numbers.
- R11: The result write enable is 1 for opcodes 0 to 7. Opcode 8 and the unassigned opcodes 9 to 15 clear it, and the unassigned opcodes drive a result of 0000.
- R12: For opcodes 2, 3, 4, 5 and 8, Cin has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| carry_i | input | 1 | Stored carry bit from the status register |
| result_o | output | 4 | Operation result |
| carry_o | output | 1 | New carry value |
| carry_we_o | output | 1 | Carry write enable |
| result_we_o | output | 1 | Result register write enable |
| zero_o | output | 1 | Result is all zeros |
| less_o | output | 1 | A below B, unsigned |

## Verification
The bench applies every opcode with every operand pair and both carry values. This covers the wrap points that catch a wrong carry: 15 + 15 + 1 and 0 − 15 − 1. A design that inverted the borrow sense would report carry on 5 − 3. A design that let the carry leak into compare or the logic operations would shift the result by one, or flip bit 0, only when Cin is set. A design that shifted in 0 instead of Cin would break nibble chaining, and the bench would see this on every shift with Cin = 1. The bench also checks that the stored carry passes through untouched on non-carry operations, and that the zero flag on compare tracks equality rather than a zeroed result bus.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_ADD = 4'd0;
    localparam logic [OP_W-1:0] OP_SUB = 4'd1;
    localparam logic [OP_W-1:0] OP_AND = 4'd2;
    localparam logic [OP_W-1:0] OP_OR  = 4'd3;
    localparam logic [OP_W-1:0] OP_NOT = 4'd4;
    localparam logic [OP_W-1:0] OP_XOR = 4'd5;
    localparam logic [OP_W-1:0] OP_SHL = 4'd6;
    localparam logic [OP_W-1:0] OP_SHR = 4'd7;
    localparam logic [OP_W-1:0] OP_CMP = 4'd8;

    // selector for the bitwise unit
    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } logic_sel_e;

endpackage

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         carry_i,
    input  logic         sub_i,
    input  logic         use_carry_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    localparam int SW = W + 1;

    logic [W-1:0]  b_eff;
    logic          cin_eff;
    logic [SW-1:0] sum_full;

    always_comb begin
        // subtraction as A + ~B + ~borrow_in
        b_eff    = sub_i ? ~b_i : b_i;
        cin_eff  = sub_i ? ~(use_carry_i & carry_i) : (use_carry_i & carry_i);
        sum_full = {1'b0, a_i} + {1'b0, b_eff} + {{(SW-1){1'b0}}, cin_eff};
        sum_o    = sum_full[W-1:0];
        // for subtraction the carry reported is a borrow
        carry_o  = sub_i ? ~sum_full[W] : sum_full[W];
    end
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] res_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (sel_i)
                LG_AND:  res_o[i] = a_i[i] & b_i[i];
                LG_OR:   res_o[i] = a_i[i] | b_i[i];
                LG_XOR:  res_o[i] = a_i[i] ^ b_i[i];
                default: res_o[i] = ~a_i[i];
            endcase
        end
    end
endmodule

// File: rtl/alu4_shift.sv
module alu4_shift #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic         carry_i,
    input  logic         left_i,
    output logic [W-1:0] res_o,
    output logic         carry_o
);
    always_comb begin
        if (left_i) begin
            res_o   = {a_i[W-2:0], carry_i};
            carry_o = a_i[W-1];
        end else begin
            res_o   = {carry_i, a_i[W-1:1]};
            carry_o = a_i[0];
        end
    end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            carry_i,
    output logic [W-1:0]    result_o,
    output logic            carry_o,
    output logic            carry_we_o,
    output logic            result_we_o,
    output logic            zero_o,
    output logic            less_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         cout;
        logic         cwe;
        logic         rwe;
    } alu_out_t;

    alu_out_t     out_d;
    logic         is_sub;
    logic [W-1:0] as_sum;
    logic         as_cout;
    logic [W-1:0] cmp_diff;
    logic         cmp_borrow;
    logic_sel_e   lg_sel;
    logic [W-1:0] lg_res;
    logic [W-1:0] sh_res;
    logic         sh_cout;

    assign is_sub = (op_i == OP_SUB);

    // chained add/subtract path
    alu4_addsub #(.W(W)) u_arith (
        .a_i         (a_i),
        .b_i         (b_i),
        .carry_i     (carry_i),
        .sub_i       (is_sub),
        .use_carry_i (1'b1),
        .sum_o       (as_sum),
        .carry_o     (as_cout)
    );

    // carry-free comparator, also the source of the less flag
    alu4_addsub #(.W(W)) u_cmp (
        .a_i         (a_i),
        .b_i         (b_i),
        .carry_i     (1'b0),
        .sub_i       (1'b1),
        .use_carry_i (1'b0),
        .sum_o       (cmp_diff),
        .carry_o     (cmp_borrow)
    );

    always_comb begin
        case (op_i)
            OP_AND:  lg_sel = LG_AND;
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_NOT;
        endcase
    end

    alu4_logic #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (lg_sel),
        .res_o (lg_res)
    );

    alu4_shift #(.W(W)) u_shift (
        .a_i     (a_i),
        .carry_i (carry_i),
        .left_i  (op_i == OP_SHL),
        .res_o   (sh_res),
        .carry_o (sh_cout)
    );

    always_comb begin
        out_d.res  = '0;
        out_d.cout = carry_i;
        out_d.cwe  = 1'b0;
        out_d.rwe  = 1'b0;
        case (op_i)
            OP_ADD, OP_SUB: begin
                out_d.res  = as_sum;
                out_d.cout = as_cout;
                out_d.cwe  = 1'b1;
                out_d.rwe  = 1'b1;
            end
            OP_SHL, OP_SHR: begin
                out_d.res  = sh_res;
                out_d.cout = sh_cout;
                out_d.cwe  = 1'b1;
                out_d.rwe  = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                out_d.res = lg_res;
                out_d.rwe = 1'b1;
            end
            OP_CMP: begin
                out_d.res = cmp_diff;
            end
            default: ;
        endcase
    end

    assign result_o    = out_d.res;
    assign carry_o     = out_d.cout;
    assign carry_we_o  = out_d.cwe;
    assign result_we_o = out_d.rwe;
    assign zero_o      = (out_d.res == '0);
    assign less_o      = cmp_borrow;

endmodule

// File: rtl/alu4_checker.sv
module alu4_checker
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input logic [OP_W-1:0] op_i,
    input logic [W-1:0]    a_i,
    input logic [W-1:0]    b_i,
    input logic            carry_i,
    input logic [W-1:0]    result_o,
    input logic            carry_o,
    input logic            carry_we_o,
    input logic            result_we_o,
    input logic            zero_o,
    input logic            less_o
);
    logic [W:0] ref_sum;
    logic [W:0] ref_need;

    always_comb begin
        ref_sum  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, carry_i};
        ref_need = {1'b0, b_i} + {{W{1'b0}}, carry_i};

        if (op_i == OP_ADD)
            a_r1_add_sum: assert ({carry_o, result_o} == ref_sum)
                else $error("add sum mismatch");

        if (op_i == OP_SUB)
            a_r2_sub_borrow: assert (carry_o == ({1'b0, a_i} < ref_need))
                else $error("subtract borrow mismatch");

        if (op_i == OP_CMP)
            a_r7_cmp_no_write: assert (!result_we_o && !carry_we_o)
                else $error("compare wrote a register");

        if (!carry_we_o)
            a_r8_carry_kept: assert (carry_o == carry_i)
                else $error("carry not preserved");

        a_r9_zero_flag: assert (zero_o == (result_o == '0))
            else $error("zero flag mismatch");

        a_r10_less_flag: assert (less_o == (a_i < b_i))
            else $error("less flag mismatch");
    end
endmodule

bind alu4_core alu4_checker #(.W(W)) u_alu4_checker (
    .op_i        (op_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .carry_i     (carry_i),
    .result_o    (result_o),
    .carry_o     (carry_o),
    .carry_we_o  (carry_we_o),
    .result_we_o (result_we_o),
    .zero_o      (zero_o),
    .less_o      (less_o)
);

// File: tb/tb_alu4_core.sv
module tb_alu4_core;

    logic       clk = 1'b0;
    logic [3:0] op_i;
    logic [3:0] a_i;
    logic [3:0] b_i;
    logic       carry_i;
    logic [3:0] result_o;
    logic       carry_o;
    logic       carry_we_o;
    logic       result_we_o;
    logic       zero_o;
    logic       less_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    typedef struct {
        int op;
        int a;
        int b;
        int c;
        int res;
        int co;
        int cwe;
        int rwe;
        int zero;
        int less;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;  // 50 MHz

    alu4_core dut (
        .op_i        (op_i),
        .a_i         (a_i),
        .b_i         (b_i),
        .carry_i     (carry_i),
        .result_o    (result_o),
        .carry_o     (carry_o),
        .carry_we_o  (carry_we_o),
        .result_we_o (result_we_o),
        .zero_o      (zero_o),
        .less_o      (less_o)
    );

    function automatic item_t model(int op, int a, int b, int c);
        item_t t;
        int    d;
        t.op = op; t.a = a; t.b = b; t.c = c;
        t.co = c; t.cwe = 0; t.rwe = 1; t.res = 0;
        case (op)
            0: begin d = a + b + c; t.res = d % 16; t.co = (d >= 16); t.cwe = 1; end
            1: begin d = a - b - c; t.res = (d + 32) % 16; t.co = (d < 0); t.cwe = 1; end
            2: t.res = a & b;
            3: t.res = a | b;
            4: t.res = 15 - a;
            5: t.res = a ^ b;
            6: begin t.res = ((a * 2) + c) % 16; t.co = a / 8; t.cwe = 1; end
            7: begin t.res = (a / 2) + c * 8; t.co = a % 2; t.cwe = 1; end
            8: begin t.res = (a - b + 16) % 16; t.rwe = 0; end
            default: begin t.res = 0; t.rwe = 0; end
        endcase
        t.zero = (t.res == 0);
        t.less = (a < b);
        return t;
    endfunction

    function automatic string res_tag(int op, int c);
        if (c == 1 && (op == 2 || op == 3 || op == 4 || op == 5 || op == 8))
            return "R12";
        case (op)
            0: return "R1";
            1: return "R2";
            6: return "R3";
            7: return "R4";
            2, 3, 5: return "R5";
            4: return "R6";
            8: return "R7";
            default: return "R11";
        endcase
    endfunction

    function automatic string co_tag(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            6: return "R3";
            7: return "R4";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp, item_t t);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s op=%0d a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
                     tag, what, t.op, t.a, t.b, t.c, act, exp);
        end
    endtask

    task automatic drive(int op, int a, int b, int c);
        @(negedge clk);
        op_i    = 4'(op);
        a_i     = 4'(a);
        b_i     = 4'(b);
        carry_i = 1'(c);
        sb_q.push_back(model(op, a, b, c));
    endtask

    // monitor: inputs change at falling edges, compare at rising edges
    initial begin
        forever begin
            @(posedge clk);
            if (sb_q.size() > 0) begin
                item_t t;
                t = sb_q.pop_front();
                check(res_tag(t.op, t.c), "result",   int'(result_o),    t.res,  t);
                check(co_tag(t.op),       "carry",    int'(carry_o),     t.co,   t);
                check("R8",               "carry_we", int'(carry_we_o),  t.cwe,  t);
                check("R11",              "result_we",int'(result_we_o), t.rwe,  t);
                check("R9",               "zero",     int'(zero_o),      t.zero, t);
                check("R10",              "less",     int'(less_o),      t.less, t);
            end
        end
    end

    initial begin
        op_i = '0; a_i = '0; b_i = '0; carry_i = 1'b0;
        // directed corners: chained overflow and underflow, compare equality
        drive(0, 15, 15, 1);   // R1 wrap
        drive(1, 0, 15, 1);    // R2 deep borrow
        drive(1, 5, 3, 0);     // R2 no borrow
        drive(8, 9, 9, 1);     // R7 equal, R12 carry ignored
        drive(6, 8, 0, 1);     // R3 carry chained in
        drive(7, 1, 0, 1);     // R4 carry chained in
        // full sweep
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    for (int c = 0; c < 2; c++)
                        drive(op, a, b, c);
        @(posedge clk);
        @(posedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule